// File: doc/BRIEF.md
# Hop-Count Label Scheduler

This block rewrites the label of each packet arriving at a router node and picks what the node does with it. A label carries a destination address and a hop-limit count. The scheduler looks up the address in a forwarding table that software can program. The table returns a replacement address and an output port. The block lowers the hop-limit count by one and then chooses one of three actions:

- send the packet straight through to its port;
- divert it to the shared regeneration and error-correction buffer;
- steer it to the discard port.

A packet is diverted to the buffer in two cases: every `HOP_N` hops, which the block detects when the low bits of the updated count are all zero, or when its chosen port is busy. A packet whose count reaches zero is discarded. Edge nodes are expected to load counts of the form m·`HOP_N`−1, so that the count hits zero exactly on the last hop.

Labels are accepted through a valid/ready handshake. The registered result appears on the following cycle with a one-cycle strobe. Table writes take priority over label acceptance.

Top module: `label_sched`

## Requirements
- R1: Label layout: bits [15:8] hold the address, bits [4:0] hold the hop count, and bits [7:5] are copied to the output label unchanged.
- R2: The output hop count equals the input count minus one. An input count of zero stays zero.
- R3: When the updated count is zero, the action is 2 (discard), `port_o` equals `DISCARD_PORT` (7), `buf_req_o` is 0, and `port_busy_i` has no effect.
- R4: When the updated count is non-zero and its low log2(`HOP_N`) bits (bits [1:0] for `HOP_N`=4) are zero, the action is 1 (buffer), `buf_req_o` is 1 and `port_o` is the table port.
- R5: When the updated count is non-zero and `port_busy_i[table port]` is 1, the action is 1 (buffer) and `buf_req_o` is 1.
- R6: In every other case the action is 0 (pass), `buf_req_o` is 0 and `port_o` is the table port.
- R7: The output address field is the new address stored in the table entry indexed by the input address field.
- R8: When `tbl_we_i` is high, the entry at `tbl_addr_i` is written with {`tbl_addr_new_i`, `tbl_port_i`}, and `label_ready_o` is low in that cycle.
- R9: `out_valid_o` is high for exactly the one cycle after each accepted label (`label_valid_i` && `label_ready_o`). Without an acceptance, the outputs hold their values.
- R10: After reset, `out_valid_o` and `buf_req_o` are 0, `label_ready_o` is 1, and every table entry reads as address 0, port 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tbl_we_i | input | 1 | Table write enable |
| tbl_addr_i | input | 8 | Table entry index to write |
| tbl_addr_new_i | input | 8 | Replacement address to store |
| tbl_port_i | input | 3 | Output port to store |
| label_valid_i | input | 1 | Input label valid |
| label_ready_o | output | 1 | Label can be accepted this cycle |
| label_i | input | 16 | Incoming label |
| port_busy_i | input | 8 | Per-port contention flags |
| out_valid_o | output | 1 | Result strobe |
| label_o | output | 16 | Rewritten label |
| port_o | output | 3 | Selected switch output port |
| action_o | output | 2 | 0 pass, 1 buffer, 2 discard |
| buf_req_o | output | 1 | Buffer request, valid with out_valid_o |

## Verification
The table is filled with an address-dependent pattern. Every address is then combined with every one of the 32 hop counts, so that zero and one (discard), counts that land on a multiple of four (periodic buffering) and all others (pass) are each covered at every table entry. A busy vector that rotates with the address and count sometimes hits the chosen port and sometimes does not. This separates contention diversion from periodic diversion, and shows that busy flags are ignored on discard. The reserved bits vary with each label to confirm they are passed through. A reset-state lookup, and a label offered during a table write, check the table's reset contents and the write-over-accept priority.

// File: rtl/label_sched_pkg.sv
package label_sched_pkg;
  typedef enum logic [1:0] {
    ACT_PASS = 2'd0,
    ACT_BUF  = 2'd1,
    ACT_DROP = 2'd2
  } act_e;
endpackage

// File: rtl/lsch_fwd_table.sv
module lsch_fwd_table #(
  parameter int ADDR_W = 8,
  parameter int PORT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [ADDR_W-1:0] wnew_i,
  input  logic [PORT_W-1:0] wport_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [ADDR_W-1:0] rnew_o,
  output logic [PORT_W-1:0] rport_o
);
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int ENTRY_W = ADDR_W + PORT_W;

  logic [ENTRY_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= {wnew_i, wport_i};
    end
  end

  assign {rnew_o, rport_o} = mem_q[raddr_i];
endmodule

// File: rtl/lsch_decide.sv
module lsch_decide
  import label_sched_pkg::*;
#(
  parameter int                 TTL_W        = 5,
  parameter int                 PORT_W       = 3,
  parameter int                 HOP_N        = 4,
  parameter logic [PORT_W-1:0]  DISCARD_PORT = '1
) (
  input  logic [TTL_W-1:0]        ttl_i,
  input  logic [PORT_W-1:0]       tbl_port_i,
  input  logic [(1<<PORT_W)-1:0]  busy_i,
  output logic [TTL_W-1:0]        ttl_o,
  output logic [PORT_W-1:0]       port_o,
  output act_e                    act_o
);
  localparam int HOP_LG = $clog2(HOP_N);

  logic hop_hit, contended, expired;

  // saturating decrement
  assign ttl_o     = (ttl_i == '0) ? '0 : ttl_i - TTL_W'(1);
  assign expired   = (ttl_o == '0);
  assign contended = busy_i[tbl_port_i];

  generate
    if (HOP_LG == 0) begin : g_every_hop
      assign hop_hit = 1'b1;
    end else begin : g_mod_hop
      assign hop_hit = ~|ttl_o[HOP_LG-1:0];
    end
  endgenerate

  // priority: discard > buffer > pass
  always_comb begin
    if (expired) begin
      act_o  = ACT_DROP;
      port_o = DISCARD_PORT;
    end else if (hop_hit || contended) begin
      act_o  = ACT_BUF;
      port_o = tbl_port_i;
    end else begin
      act_o  = ACT_PASS;
      port_o = tbl_port_i;
    end
  end
endmodule

// File: rtl/label_sched.sv
module label_sched
  import label_sched_pkg::*;
#(
  parameter int                ADDR_W       = 8,
  parameter int                TTL_W        = 5,
  parameter int                LABEL_W      = 16,
  parameter int                PORT_W       = 3,
  parameter int                HOP_N        = 4,
  parameter logic [PORT_W-1:0] DISCARD_PORT = '1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tbl_we_i,
  input  logic [ADDR_W-1:0]        tbl_addr_i,
  input  logic [ADDR_W-1:0]        tbl_addr_new_i,
  input  logic [PORT_W-1:0]        tbl_port_i,
  input  logic                     label_valid_i,
  output logic                     label_ready_o,
  input  logic [LABEL_W-1:0]       label_i,
  input  logic [(1<<PORT_W)-1:0]   port_busy_i,
  output logic                     out_valid_o,
  output logic [LABEL_W-1:0]       label_o,
  output logic [PORT_W-1:0]        port_o,
  output logic [1:0]               action_o,
  output logic                     buf_req_o
);
  localparam int RSV_W  = LABEL_W - ADDR_W - TTL_W;
  localparam int ADDR_L = LABEL_W - ADDR_W;

  logic [ADDR_W-1:0] in_addr, new_addr;
  logic [RSV_W-1:0]  in_rsv;
  logic [TTL_W-1:0]  in_ttl, new_ttl;
  logic [PORT_W-1:0] tbl_port, sel_port;
  act_e              act;
  logic              accept;

  assign in_addr = label_i[LABEL_W-1:ADDR_L];
  assign in_rsv  = label_i[ADDR_L-1:TTL_W];
  assign in_ttl  = label_i[TTL_W-1:0];

  assign label_ready_o = !tbl_we_i;
  assign accept        = label_valid_i && label_ready_o;

  lsch_fwd_table #(.ADDR_W(ADDR_W), .PORT_W(PORT_W)) u_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (tbl_we_i),
    .waddr_i (tbl_addr_i),
    .wnew_i  (tbl_addr_new_i),
    .wport_i (tbl_port_i),
    .raddr_i (in_addr),
    .rnew_o  (new_addr),
    .rport_o (tbl_port)
  );

  lsch_decide #(
    .TTL_W(TTL_W), .PORT_W(PORT_W), .HOP_N(HOP_N), .DISCARD_PORT(DISCARD_PORT)
  ) u_decide (
    .ttl_i      (in_ttl),
    .tbl_port_i (tbl_port),
    .busy_i     (port_busy_i),
    .ttl_o      (new_ttl),
    .port_o     (sel_port),
    .act_o      (act)
  );

  logic               valid_q;
  logic [LABEL_W-1:0] label_q;
  logic [PORT_W-1:0]  port_q;
  act_e               act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      label_q <= '0;
      port_q  <= '0;
      act_q   <= ACT_PASS;
    end else begin
      valid_q <= accept;
      if (accept) begin
        label_q <= {new_addr, in_rsv, new_ttl};
        port_q  <= sel_port;
        act_q   <= act;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign label_o     = label_q;
  assign port_o      = port_q;
  assign action_o    = act_q;
  assign buf_req_o   = valid_q && (act_q == ACT_BUF);

  // R9
  accept_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);
  // R9
  no_spurious_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> !out_valid_o);
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> ($stable(label_o) && $stable(port_o) && $stable(action_o)));
  // R2
  ttl_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (label_o[TTL_W-1:0] ==
      (($past(label_i[TTL_W-1:0]) == '0) ? '0 : TTL_W'($past(label_i[TTL_W-1:0]) - TTL_W'(1)))));
  // R1
  rsv_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (label_o[ADDR_L-1:TTL_W] == $past(label_i[ADDR_L-1:TTL_W])));
  // R3
  drop_port_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && action_o == ACT_DROP) |->
      (port_o == DISCARD_PORT && label_o[TTL_W-1:0] == '0 && !buf_req_o));
  // R6
  pass_ttl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && action_o == ACT_PASS) |-> (label_o[TTL_W-1:0] != '0 && !buf_req_o));
  // R10
  buf_req_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> !buf_req_o);
endmodule

// File: tb/label_sched_tb.sv
module label_sched_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [7:0]  tbl_addr = '0, tbl_new = '0;
  logic [2:0]  tbl_port = '0;
  logic        lv = 1'b0;
  logic        lr;
  logic [15:0] lin = '0;
  logic [7:0]  busy = '0;
  logic        ov, breq;
  logic [15:0] lout;
  logic [2:0]  pout;
  logic [1:0]  aout;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  label_sched u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tbl_we_i(tbl_we), .tbl_addr_i(tbl_addr),
    .tbl_addr_new_i(tbl_new), .tbl_port_i(tbl_port), .label_valid_i(lv),
    .label_ready_o(lr), .label_i(lin), .port_busy_i(busy), .out_valid_o(ov),
    .label_o(lout), .port_o(pout), .action_o(aout), .buf_req_o(breq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] l, input logic [7:0] b);
    @(negedge clk);
    lin = l; busy = b; lv = 1'b1;
    @(negedge clk);
    lv = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(ov == 1'b0, "R10 out_valid", ov, 0);
    chk(breq == 1'b0, "R10 buf_req", breq, 0);
    chk(lr == 1'b1, "R10 ready", lr, 1);
    rst_n = 1'b1;
    // R10 empty table: addr 0, port 0; ttl 10 -> 9 passes
    send({8'hC3, 3'b101, 5'd10}, 8'h00);
    chk(ov == 1'b1, "R9 valid after accept", ov, 1);
    chk(lout == {8'h00, 3'b101, 5'd9}, "R10 reset table label", lout, {8'h00, 3'b101, 5'd9});
    chk(pout == 3'd0, "R10 reset table port", pout, 0);
    chk(aout == 2'd0, "R6 pass", aout, 0);
    @(negedge clk);
    chk(ov == 1'b0, "R9 single pulse", ov, 0);
    chk(lout == {8'h00, 3'b101, 5'd9}, "R9 hold", lout, {8'h00, 3'b101, 5'd9});

    // R8 program table; label offered during a write is refused
    for (int a = 0; a < 256; a++) begin
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 8'(a); tbl_new = 8'(a) ^ 8'h5A; tbl_port = 3'(a);
      if (a == 17) begin
        lv = 1'b1; lin = {8'd3, 3'd0, 5'd6};
        #1;
        chk(lr == 1'b0, "R8 ready low on write", lr, 0);
      end
    end
    @(negedge clk);
    tbl_we = 1'b0;
    chk(ov == 1'b0, "R8 no accept during write", ov, 0);
    lv = 1'b0;

    // R1-style full sweep
    for (int a = 0; a < 256; a++) begin
      for (int t = 0; t < 32; t++) begin
        logic [2:0] rsv, tp, ep;
        logic [4:0] nt;
        logic [7:0] b;
        int ea;
        rsv = 3'(a + t);
        tp  = 3'(a);
        b   = 8'(1 << ((a + 3 * t) % 8));
        nt  = (t == 0) ? 5'd0 : 5'(t - 1);
        if (nt == 0) begin ea = 2; ep = 3'd7; end
        else if (nt[1:0] == 2'b00 || b[tp]) begin ea = 1; ep = tp; end
        else begin ea = 0; ep = tp; end
        send({8'(a), rsv, 5'(t)}, b);
        // R7 address, R1 reserved, R2 count
        chk(lout == {8'(a) ^ 8'h5A, rsv, nt}, "R7/R1/R2 label", lout, {8'(a) ^ 8'h5A, rsv, nt});
        if (ea == 2)
          chk(aout == 2'd2 && pout == ep && !breq, "R3 discard", {aout, pout, breq}, {2'd2, ep, 1'b0});
        else if (ea == 1)
          chk(aout == 2'd1 && pout == ep && breq,
              (nt[1:0] == 0) ? "R4 hop buffer" : "R5 busy buffer",
              {aout, pout, breq}, {2'd1, ep, 1'b1});
        else
          chk(aout == 2'd0 && pout == ep && !breq, "R6 pass", {aout, pout, breq}, {2'd0, ep, 1'b0});
        chk(ov == 1'b1, "R9 strobe", ov, 1);
      end
    end
    @(negedge clk);
    chk(ov == 1'b0 && !breq, "R9 idle after sweep", {ov, breq}, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule